// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits between a host I/O bus and the packet buffer of a legacy network controller. Software first programs a buffer address, a byte count and a pair of ring bounds. It then moves data through one data port, one access after another. Each access to the port reaches buffer memory at the current address. The block then steps the address forward, takes the access size off the count, and folds the address back to the ring start when it lands on the ring stop. When the count drains to zero, a completion flag is raised.

The buffer has two regions: a small low area that holds the station address bytes, and a packet RAM placed at a fixed base. An access that falls in neither region reads back as all ones and writes nothing. The data port accepts 8-, 16- and 32-bit accesses. Multi-byte accesses drop the low address bits and use little-endian byte order. The block decodes a 32-byte I/O window that holds the control registers, the data port and an inert reset port.

Top module: `rdma_port`

## Requirements
- R1: After reset, the address, count, ring bounds, status and mask registers all read zero, and `irq` is low.
- R2: A buffer access is valid when its aligned address is below PROM_BYTES (default 32), or lies in RAM_BASE up to RAM_BASE+RAM_BYTES-1 (default 0x4000 to 0x43FF). A write to any other address changes no stored byte.
- R3: A data-port read at an invalid address returns all ones at the access width, zero-extended: 0x000000FF for 8 bits, 0x0000FFFF for 16 bits and 0xFFFFFFFF for 32 bits.
- R4: `io_size` is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. A 16-bit access clears address bit 0 and a 32-bit access clears bits 1:0. The byte at the lowest address sits in data bits 7:0 (little-endian).
- R5: Each data-port access that is not suppressed adds the access size in bytes (1, 2 or 4) to the unaligned address register and subtracts the same amount from the count, modulo 2^16.
- R6: If the address produced by an access equals the ring stop page times 256, the address register is loaded with the ring start page times 256 instead.
- R7: An access that leaves the count at zero sets status bit 6. Writing 1 to a status bit clears it. `irq` is the OR of the status bits ANDed with the mask register.
- R8: A data-port write of any size while the count is zero is ignored: no memory, address or count change.
- R9: Window offsets are: 0x00 ring start page, 0x01 ring stop page, 0x02/0x03 address low/high byte, 0x04/0x05 count low/high byte, 0x06 status (write 1 to clear), 0x07 mask, and 0x10 the data port. Offsets 0x08–0x0F and 0x11–0x1F, including the reset port at 0x1F, read zero, and writes to them have no effect.
- R10: A data-port read with the count at zero still reads memory and advances, so the count wraps to 0x10000 minus the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 5 | Byte offset within the I/O window |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_size | input | 2 | Access width code (0: 8, 1: 16, 2/3: 32 bits) |
| io_wdata | input | 32 | Write data, register writes use bits 7:0 |
| io_rdata | output | 32 | Read data for the addressed offset, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
Random runs program ring bounds, address and count in four address classes: the station-address area, the middle of packet RAM, just below the ring stop, and the gaps outside both regions. They then mix the three access sizes, both directions and unaligned start addresses. The four classes separate correct region decode from aliasing, and a correct wrap from a stop that is stepped over. Small counts drive the count through zero often. This separates suppressed writes from reads that wrap the count, and shows the completion flag being set and then cleared by software. A final sweep of the whole buffer shows whether any dropped or gated write still reached memory.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_sz_e;

    typedef struct packed {
        logic [7:0]  ring_lo;
        logic [7:0]  ring_hi;
        logic [15:0] ptr;
        logic [15:0] left;
        logic [7:0]  stat;
        logic [7:0]  mask;
    } ctrl_s;

    localparam int DONE_BIT = 6;

    localparam logic [2:0] OFF_RING_LO = 3'd0;
    localparam logic [2:0] OFF_RING_HI = 3'd1;
    localparam logic [2:0] OFF_PTR_LO  = 3'd2;
    localparam logic [2:0] OFF_PTR_HI  = 3'd3;
    localparam logic [2:0] OFF_LEFT_LO = 3'd4;
    localparam logic [2:0] OFF_LEFT_HI = 3'd5;
    localparam logic [2:0] OFF_STAT    = 3'd6;
    localparam logic [2:0] OFF_MASK    = 3'd7;

    function automatic logic [15:0] step_of(acc_sz_e s);
        case (s)
            SZ_BYTE: return 16'd1;
            SZ_HALF: return 16'd2;
            default: return 16'd4;
        endcase
    endfunction

    function automatic logic [15:0] align_of(logic [15:0] a, acc_sz_e s);
        case (s)
            SZ_BYTE: return a;
            SZ_HALF: return {a[15:1], 1'b0};
            default: return {a[15:2], 2'b00};
        endcase
    endfunction

endpackage

// File: rtl/rdma_decode.sv
module rdma_decode (
    input  logic [4:0] io_addr,
    input  logic       io_rd,
    input  logic       io_wr,
    output logic       dp_sel,
    output logic       reg_sel,
    output logic       dp_rd,
    output logic       dp_wr,
    output logic       reg_wr
);
    always_comb begin
        dp_sel  = (io_addr == 5'h10);
        reg_sel = (io_addr[4:3] == 2'b00);
        dp_wr   = dp_sel && io_wr;
        dp_rd   = dp_sel && io_rd && !io_wr;
        reg_wr  = reg_sel && io_wr;
    end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dp_rd,
    input  logic        dp_wr,
    input  acc_sz_e     size,
    input  logic        reg_wr,
    input  logic [2:0]  reg_off,
    input  logic [7:0]  wbyte,
    output ctrl_s       st_q,
    output logic [15:0] buf_addr,
    output logic        buf_we
);
    ctrl_s       st_d;
    logic [15:0] step;
    logic [15:0] nxt_ptr;
    logic        gated;
    logic        take;

    always_comb begin
        st_d     = st_q;
        step     = step_of(size);
        gated    = dp_wr && (st_q.left == 16'd0);
        take     = (dp_rd || dp_wr) && !gated;
        buf_we   = dp_wr && !gated;
        buf_addr = align_of(st_q.ptr, size);
        nxt_ptr  = st_q.ptr + step;
        if (nxt_ptr == {st_q.ring_hi, 8'h00}) begin
            nxt_ptr = {st_q.ring_lo, 8'h00};
        end
        if (take) begin
            st_d.ptr  = nxt_ptr;
            st_d.left = st_q.left - step;
            if (st_d.left == 16'd0) begin
                st_d.stat[DONE_BIT] = 1'b1;
            end
        end
        if (reg_wr) begin
            case (reg_off)
                OFF_RING_LO: st_d.ring_lo    = wbyte;
                OFF_RING_HI: st_d.ring_hi    = wbyte;
                OFF_PTR_LO:  st_d.ptr[7:0]   = wbyte;
                OFF_PTR_HI:  st_d.ptr[15:8]  = wbyte;
                OFF_LEFT_LO: st_d.left[7:0]  = wbyte;
                OFF_LEFT_HI: st_d.left[15:8] = wbyte;
                OFF_STAT:    st_d.stat       = st_q.stat & ~wbyte;
                default:     st_d.mask       = wbyte;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rdma_buf.sv
module rdma_buf
    import rdma_pkg::*;
#(
    parameter int          PROM_BYTES = 32,
    parameter logic [15:0] RAM_BASE   = 16'h4000,
    parameter int          RAM_BYTES  = 1024
) (
    input  logic        clk,
    input  logic [15:0] addr,
    input  acc_sz_e     size,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam int          PROM_WORDS = PROM_BYTES / 4;
    localparam int          WORDS      = (PROM_BYTES + RAM_BYTES) / 4;
    localparam int          IW         = $clog2(WORDS);
    localparam logic [16:0] RAM_END    = 17'(RAM_BASE) + 17'(RAM_BYTES);
    localparam logic [15:0] PROM_LIM   = 16'(PROM_BYTES);

    logic [31:0]   mem [WORDS];
    logic          hit;
    logic [15:0]   ram_off;
    logic [IW-1:0] idx;
    logic [3:0]    be;
    logic [31:0]   wlane;
    logic [31:0]   word;

    always_comb begin
        hit     = (addr < PROM_LIM) ||
                  ((addr >= RAM_BASE) && ({1'b0, addr} < RAM_END));
        ram_off = addr - RAM_BASE;
        if (addr < PROM_LIM) begin
            idx = IW'(addr >> 2);
        end else begin
            idx = IW'(ram_off >> 2) + IW'(PROM_WORDS);
        end
        case (size)
            SZ_BYTE: begin
                be    = 4'b0001 << addr[1:0];
                wlane = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                be    = addr[1] ? 4'b1100 : 4'b0011;
                wlane = {2{wdata[15:0]}};
            end
            default: begin
                be    = 4'b1111;
                wlane = wdata;
            end
        endcase
        word = hit ? mem[idx] : 32'hFFFF_FFFF;
        case (size)
            SZ_BYTE: rdata = {24'h0, word[8*addr[1:0] +: 8]};
            SZ_HALF: rdata = {16'h0, addr[1] ? word[31:16] : word[15:0]};
            default: rdata = word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (we && hit) begin
            for (int l = 0; l < 4; l++) begin
                if (be[l]) begin
                    mem[idx][8*l +: 8] <= wlane[8*l +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
    import rdma_pkg::*;
#(
    parameter int          PROM_BYTES = 32,
    parameter logic [15:0] RAM_BASE   = 16'h4000,
    parameter int          RAM_BYTES  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        irq
);
    logic        dp_sel, reg_sel, dp_rd, dp_wr, reg_wr;
    ctrl_s       st;
    logic [15:0] buf_addr;
    logic        buf_we;
    logic [31:0] buf_rdata;
    logic [7:0]  reg_val;
    acc_sz_e     size;

    assign size = acc_sz_e'(io_size);

    rdma_decode u_dec (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .dp_sel  (dp_sel),
        .reg_sel (reg_sel),
        .dp_rd   (dp_rd),
        .dp_wr   (dp_wr),
        .reg_wr  (reg_wr)
    );

    rdma_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dp_rd    (dp_rd),
        .dp_wr    (dp_wr),
        .size     (size),
        .reg_wr   (reg_wr),
        .reg_off  (io_addr[2:0]),
        .wbyte    (io_wdata[7:0]),
        .st_q     (st),
        .buf_addr (buf_addr),
        .buf_we   (buf_we)
    );

    rdma_buf #(
        .PROM_BYTES (PROM_BYTES),
        .RAM_BASE   (RAM_BASE),
        .RAM_BYTES  (RAM_BYTES)
    ) u_buf (
        .clk   (clk),
        .addr  (buf_addr),
        .size  (size),
        .we    (buf_we),
        .wdata (io_wdata),
        .rdata (buf_rdata)
    );

    always_comb begin
        case (io_addr[2:0])
            OFF_RING_LO: reg_val = st.ring_lo;
            OFF_RING_HI: reg_val = st.ring_hi;
            OFF_PTR_LO:  reg_val = st.ptr[7:0];
            OFF_PTR_HI:  reg_val = st.ptr[15:8];
            OFF_LEFT_LO: reg_val = st.left[7:0];
            OFF_LEFT_HI: reg_val = st.left[15:8];
            OFF_STAT:    reg_val = st.stat;
            default:     reg_val = st.mask;
        endcase
        if (dp_sel) begin
            io_rdata = buf_rdata;
        end else if (reg_sel) begin
            io_rdata = {24'h0, reg_val};
        end else begin
            io_rdata = 32'h0;
        end
    end

    assign irq = |(st.stat & st.mask);
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
    parameter int          PROM_BYTES = 32,
    parameter logic [15:0] RAM_BASE   = 16'h4000,
    parameter int          RAM_BYTES  = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [1:0]  io_size,
    input logic [31:0] io_rdata,
    input logic [15:0] ptr,
    input logic [15:0] left,
    input logic [7:0]  stat,
    input logic [7:0]  ring_lo,
    input logic [7:0]  ring_hi
);
    localparam logic [16:0] RAM_END  = 17'(RAM_BASE) + 17'(RAM_BYTES);
    localparam logic [15:0] PROM_LIM = 16'(PROM_BYTES);

    logic        on_port;
    logic        moves;
    logic [15:0] step;
    logic [15:0] wptr;
    logic        wvalid;

    always_comb begin
        on_port = (io_addr == 5'h10);
        step    = (io_size == 2'd0) ? 16'd1 : (io_size == 2'd1) ? 16'd2 : 16'd4;
        moves   = on_port && ((io_rd && !io_wr) || (io_wr && left != 16'd0));
        wptr    = {ptr[15:2], 2'b00};
        wvalid  = (wptr < PROM_LIM) || ((wptr >= RAM_BASE) && ({1'b0, wptr} < RAM_END));
    end

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        moves |=> left == $past(left) - $past(step));

    // R8
    zero_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_port && io_wr && left == 16'd0) |=> ($stable(ptr) && $stable(left)));

    // R6
    never_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (moves && ring_lo != ring_hi) |=> ptr != {$past(ring_hi), 8'h00});

    // R7
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (moves && left == step) |=> stat[6]);

    // R9
    reset_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == 5'h1F) |-> io_rdata == 32'h0);

    // R3
    wide_miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_port && io_size[1] && !wvalid) |-> io_rdata == 32'hFFFF_FFFF);
endmodule

bind rdma_port rdma_port_chk #(
    .PROM_BYTES (PROM_BYTES),
    .RAM_BASE   (RAM_BASE),
    .RAM_BYTES  (RAM_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_size  (io_size),
    .io_rdata (io_rdata),
    .ptr      (st.ptr),
    .left     (st.left),
    .stat     (st.stat),
    .ring_lo  (st.ring_lo),
    .ring_hi  (st.ring_hi)
);

// File: tb/rdma_port_tb.sv
module rdma_port_tb;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [7:0]  prom_m [32];
    logic [7:0]  ram_m [1024];
    logic [15:0] m_ptr, m_left;
    logic [7:0]  m_lo, m_hi, m_stat, m_mask;

    always #(CLK_NS/2) clk = ~clk;

    rdma_port u_dut (
        .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_rd (io_rd),
        .io_wr (io_wr), .io_size (io_size), .io_wdata (io_wdata),
        .io_rdata (io_rdata), .irq (irq)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit valid_a(logic [15:0] a);
        return (a < 16'd32) || (a >= 16'h4000 && a < 16'h4400);
    endfunction

    function automatic logic [7:0] mget(logic [15:0] a);
        if (a < 16'd32) return prom_m[a[4:0]];
        return ram_m[a[9:0]];
    endfunction

    task automatic mput(logic [15:0] a, logic [7:0] v);
        if (a < 16'd32) prom_m[a[4:0]] = v;
        else ram_m[a[9:0]] = v;
    endtask

    task automatic io(logic [4:0] a, bit rd, bit wr, logic [1:0] sz,
                      logic [31:0] wd, output logic [31:0] got);
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr; io_size = sz; io_wdata = wd;
        #(CLK_NS/4);
        got = io_rdata;
        @(posedge clk);
        #1;
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic wreg(logic [4:0] a, logic [7:0] v);
        logic [31:0] g;
        io(a, 0, 1, 2'd0, {24'h0, v}, g);
    endtask

    task automatic rreg(logic [4:0] a, output logic [7:0] v);
        logic [31:0] g;
        io(a, 1, 0, 2'd0, 32'h0, g);
        v = g[7:0];
    endtask

    task automatic set_ptr(logic [15:0] v);
        wreg(5'h02, v[7:0]); wreg(5'h03, v[15:8]); m_ptr = v;
    endtask

    task automatic set_left(logic [15:0] v);
        wreg(5'h04, v[7:0]); wreg(5'h05, v[15:8]); m_left = v;
    endtask

    task automatic set_ring(logic [7:0] lo, logic [7:0] hi);
        wreg(5'h00, lo); wreg(5'h01, hi); m_lo = lo; m_hi = hi;
    endtask

    task automatic dp_op(bit wr, logic [1:0] sz, logic [31:0] wd, bit chk_rd);
        int n;
        logic [15:0] a;
        logic [31:0] exp, got;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        a = m_ptr & ~16'(n - 1);
        exp = 32'h0;
        for (int i = 0; i < n; i++) exp[8*i +: 8] = valid_a(a) ? mget(a + 16'(i)) : 8'hFF;
        io(5'h10, !wr, wr, sz, wd, got);
        if (!wr && chk_rd) begin
            if (valid_a(a)) check(got == exp, "R4 data read", got, exp);
            else check(got == exp, "R3 miss read", got, exp);
        end
        if (!(wr && m_left == 16'd0)) begin
            if (wr && valid_a(a))
                for (int i = 0; i < n; i++) mput(a + 16'(i), wd[8*i +: 8]);
            m_ptr = m_ptr + 16'(n);
            if (m_ptr == {m_hi, 8'h00}) m_ptr = {m_lo, 8'h00};
            m_left = m_left - 16'(n);
            if (m_left == 16'd0) m_stat[6] = 1'b1;
        end
    endtask

    task automatic verify_state(string tag);
        logic [7:0] b0, b1;
        rreg(5'h02, b0); rreg(5'h03, b1);
        check({b1, b0} == m_ptr, {tag, " R5 R6 address"}, {16'h0, b1, b0}, {16'h0, m_ptr});
        rreg(5'h04, b0); rreg(5'h05, b1);
        check({b1, b0} == m_left, {tag, " R5 count"}, {16'h0, b1, b0}, {16'h0, m_left});
        rreg(5'h06, b0);
        check(b0 == m_stat, {tag, " R7 status"}, {24'h0, b0}, {24'h0, m_stat});
        check(irq == |(m_stat & m_mask), {tag, " R7 irq"}, {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] g;
        bit          all_zero;
        int          zero_ops;
        void'($urandom(32'd1234));
        m_ptr = 0; m_left = 0; m_lo = 0; m_hi = 0; m_stat = 0; m_mask = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        all_zero = 1;
        for (int r = 0; r < 8; r++) begin
            rreg(5'(r), b);
            if (b != 8'h00) all_zero = 0;
        end
        check(all_zero, "R1 registers after reset", {31'h0, all_zero}, 32'h1);
        check(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);

        // R8 data write with zero count is ignored
        dp_op(1, 2'd2, 32'hDEAD_BEEF, 0);
        verify_state("R8 zero count write");

        // fill whole buffer through the port
        set_ring(8'h80, 8'hC0);
        set_ptr(16'h0000); set_left(16'd32);
        for (int i = 0; i < 8; i++) dp_op(1, 2'd2, $urandom, 0);
        verify_state("fill prom");
        set_ptr(16'h4000); set_left(16'd1024);
        for (int i = 0; i < 256; i++) dp_op(1, 2'd2, $urandom, 0);
        verify_state("fill ram");
        wreg(5'h06, 8'hFF); m_stat = 0;

        // R4 little-endian and alignment
        set_ptr(16'h4010); set_left(16'd4);
        dp_op(1, 2'd2, 32'h4433_2211, 0);
        set_ptr(16'h4011); set_left(16'd8);
        dp_op(0, 2'd0, 0, 1);
        set_ptr(16'h4013); dp_op(0, 2'd1, 0, 1);
        set_ptr(16'h4013); dp_op(0, 2'd2, 0, 1);
        set_ptr(16'h4012); io(5'h10, 1, 0, 2'd1, 0, g);
        check(g == 32'h0000_4433, "R4 upper half little-endian", g, 32'h4433);
        m_ptr = m_ptr + 16'd2; m_left = m_left - 16'd2;

        // R3 each width outside valid regions
        set_ptr(16'h2001); set_left(16'd20);
        dp_op(0, 2'd0, 0, 1); dp_op(0, 2'd1, 0, 1); dp_op(0, 2'd2, 0, 1);
        set_ptr(16'h4400); dp_op(0, 2'd2, 0, 1);
        set_ptr(16'h0020); dp_op(0, 2'd1, 0, 1);
        set_ptr(16'h1000); dp_op(1, 2'd2, 32'h1234_5678, 0);
        verify_state("R3 R2 miss");

        // R7 done flag, mask and write-one-to-clear
        wreg(5'h07, 8'h40); m_mask = 8'h40;
        set_ptr(16'h4100); set_left(16'd3);
        dp_op(0, 2'd1, 0, 1); dp_op(0, 2'd0, 0, 1);
        verify_state("R7 done");
        wreg(5'h06, 8'h40); m_stat[6] = 1'b0;
        verify_state("R7 cleared");

        // R10 read with zero count still advances
        dp_op(0, 2'd2, 0, 1);
        verify_state("R10 zero count read");

        // R6 wrap on exact hit of stop
        set_ring(8'h41, 8'h42);
        set_ptr(16'h41FE); set_left(16'd10);
        dp_op(0, 2'd1, 0, 1);
        verify_state("R6 wrap");

        // R9 reset port and unused offsets
        rreg(5'h1F, b);
        check(b == 8'h00, "R9 reset port reads zero", {24'h0, b}, 32'h0);
        wreg(5'h1F, 8'hFF); wreg(5'h15, 8'hFF); wreg(5'h0A, 8'hFF);
        rreg(5'h15, b);
        check(b == 8'h00, "R9 unused offset reads zero", {24'h0, b}, 32'h0);
        rreg(5'h0C, b);
        check(b == 8'h00, "R9 upper register offset reads zero", {24'h0, b}, 32'h0);
        verify_state("R9 inert writes");

        // random mix
        zero_ops = 0;
        for (int it = 0; it < 300; it++) begin
            if ($urandom % 8 == 0) begin
                logic [7:0] lo, hi;
                lo = 8'h40 + 8'($urandom % 2);
                hi = lo + 8'd1 + 8'($urandom % 2);
                set_ring(lo, hi);
                case ($urandom % 4)
                    0: set_ptr(16'($urandom % 32));
                    1: set_ptr(16'h4000 + 16'($urandom % 1024));
                    2: set_ptr({hi, 8'h00} - 16'd1 - 16'($urandom % 12));
                    default: set_ptr(($urandom % 2) ? 16'h0020 + 16'($urandom % 16'h3FE0)
                                                    : 16'h4400 + 16'($urandom % 16'h1000));
                endcase
                set_left(16'($urandom % 24));
                if ($urandom % 2) begin wreg(5'h06, 8'hFF); m_stat = 0; end
                m_mask = 8'(($urandom % 2) ? 8'h40 : 8'h00);
                wreg(5'h07, m_mask);
            end
            if (m_left == 16'd0) zero_ops++;
            dp_op($urandom % 2, 2'($urandom % 4), $urandom, 1);
            verify_state("random");
        end
        check(zero_ops > 0, "R8 random hit zero count", zero_ops, 1);

        // R2 full sweep: gated and missed writes left memory intact
        set_ring(8'h80, 8'hC0);
        set_ptr(16'h0000); set_left(16'd32);
        for (int i = 0; i < 8; i++) dp_op(0, 2'd2, 0, 1);
        set_ptr(16'h4000); set_left(16'd1024);
        for (int i = 0; i < 256; i++) dp_op(0, 2'd2, 0, 1);
        verify_state("R2 sweep");

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule